// File: doc/BRIEF.md
# Chip-Select Wait-State Generator

This block times external bus cycles on a small controller bus. Each access goes either to one of four chip-select regions or to an internal register region. On an accepted request the block decodes the target from the address. It works out how many bus clocks the strobe must stay high, then holds the strobe, the region select and the latched direction for exactly that many clocks.

Two control registers set the timing of each chip-select region. A mode register holds one no-wait bit per region plus a global bit for the internal region's length. An expansion register holds one packed 2-bit wait-count field per region. A region that has waits enabled can be stretched further by an external ready input. The internal register region ignores all of these settings except its own length bit. The block enforces the ordering rules between the two registers. An illegal write changes nothing and sets a sticky error flag.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset the strobe, all selects and the error flag are low, every region is in with-wait mode, every expansion field is 00, and an internal access lasts 2 clocks. As a result, the first access to any chip-select region lasts 2 clocks.
- R2: An address below IREG_LIMIT (default 0x0400) selects the internal region and raises `ireg_sel`. Any other address selects chip-select region `addr[15:14]` through the matching one-hot bit of `cs_sel`. Exactly one select is high in every strobe clock, and none is high outside a cycle.
- R3: A region whose no-wait bit (mode register bit i) is 1 gets a 1-clock strobe, whatever the level of `rdy`.
- R4: A region in with-wait mode gets a strobe of 1 clock plus its wait count. The count comes from expansion bits [2i+1:2i], where 00 means 1 wait, 01 means 2 waits and 10 means 3 waits.
- R5: In with-wait mode, `rdy` is sampled on the clock edge that ends the last wait. Each edge that sees `rdy` low adds one clock, and the cycle ends on the first edge that sees `rdy` high.
- R6: An internal access lasts 2 clocks when mode register bit 4 is 0 and 3 clocks when it is 1. It ignores `rdy`, the no-wait bits and the expansion fields.
- R7: A request is accepted only while the strobe is low, and the strobe rises in the clock after the accepting edge. The address and `wr` are captured on the accepting edge. The outputs `cs_sel`, `ireg_sel` and `wr_o` then stay constant for the whole cycle, even if the inputs change or another request arrives.
- R8: An expansion write that would change a field to 11 leaves that field unchanged and sets `cfg_err`.
- R9: An expansion write that would change the field of a region in no-wait mode leaves that field unchanged and sets `cfg_err`. Rewriting the field's current value raises no error.
- R10: A mode write that would switch a region to no-wait while that region's field is non-zero leaves the region in with-wait mode and sets `cfg_err`. `cfg_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled while idle |
| addr | input | ADDR_W | Access address |
| wr | input | 1 | Access direction, 1 = write |
| rdy | input | 1 | External ready, high = cycle may finish |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | 0 = mode register, 1 = expansion register |
| cfg_wdata | input | 2*N_CS | Control write data |
| strb | output | 1 | Bus strobe, high while a cycle is in progress (also serves as busy) |
| cs_sel | output | N_CS | One-hot chip-select of the current cycle |
| ireg_sel | output | 1 | Internal register region selected |
| wr_o | output | 1 | Latched direction of the current cycle |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
A wrong wait counter or a misread expansion field shows up within a single access as a strobe one or more clocks too long or too short. A bad legality decision shows up on `cfg_err` one clock after the write. It also shows up in the length of the next access to the affected region, because that length exposes whether the rejected value was stored. A latched region or direction that drifts during a cycle is visible on `cs_sel` or `wr_o` in the very clock it moves.

// File: rtl/cswg_pkg.sv
package cswg_pkg;

    localparam int CNT_W   = 2;
    localparam int FIELD_W = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tstate_e;

    // encoded field -> number of wait clocks (00:1, 01:2, 10:3)
    function automatic logic [CNT_W-1:0] wait_count(input logic [FIELD_W-1:0] f);
        return CNT_W'(f) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/cswg_cfg.sv
module cswg_cfg #(
    parameter int N_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [2*N_CS-1:0] cfg_wdata,
    output logic [N_CS-1:0]   nowait,
    output logic [2*N_CS-1:0] wexp,
    output logic              ireg_slow,
    output logic              cfg_err
);
    import cswg_pkg::*;

    typedef struct packed {
        logic [N_CS-1:0]   nowait;
        logic [2*N_CS-1:0] wexp;
        logic              slow;
        logic              err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        logic [FIELD_W-1:0] cur_f;
        logic [FIELD_W-1:0] new_f;
        cfg_d = cfg_q;
        cur_f = '0;
        new_f = '0;
        if (cfg_we) begin
            if (!cfg_sel) begin
                for (int i = 0; i < N_CS; i++) begin
                    cur_f = cfg_q.wexp[FIELD_W*i +: FIELD_W];
                    if (cfg_wdata[i] && !cfg_q.nowait[i] && (cur_f != '0)) begin
                        cfg_d.err = 1'b1;
                    end else begin
                        cfg_d.nowait[i] = cfg_wdata[i];
                    end
                end
                cfg_d.slow = cfg_wdata[N_CS];
            end else begin
                for (int i = 0; i < N_CS; i++) begin
                    cur_f = cfg_q.wexp[FIELD_W*i +: FIELD_W];
                    new_f = cfg_wdata[FIELD_W*i +: FIELD_W];
                    if (new_f != cur_f) begin
                        if ((new_f == 2'b11) || cfg_q.nowait[i]) begin
                            cfg_d.err = 1'b1;
                        end else begin
                            cfg_d.wexp[FIELD_W*i +: FIELD_W] = new_f;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign nowait    = cfg_q.nowait;
    assign wexp      = cfg_q.wexp;
    assign ireg_slow = cfg_q.slow;
    assign cfg_err   = cfg_q.err;

endmodule

// File: rtl/cswg_decode.sv
module cswg_decode #(
    parameter int              N_CS       = 4,
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] IREG_LIMIT = 16'h0400
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N_CS-1:0]           nowait,
    input  logic [2*N_CS-1:0]         wexp,
    input  logic                      ireg_slow,
    output logic [N_CS-1:0]           cs_hot,
    output logic                      is_ireg,
    output logic [cswg_pkg::CNT_W-1:0] load_cnt,
    output logic                      use_rdy
);
    import cswg_pkg::*;

    localparam int IDX_W = $clog2(N_CS);

    logic [IDX_W-1:0]   idx;
    logic [FIELD_W-1:0] field;
    logic               nw_sel;

    assign is_ireg = (addr < IREG_LIMIT);
    assign idx     = addr[ADDR_W-1 -: IDX_W];

    for (genvar g = 0; g < N_CS; g++) begin : g_hot
        assign cs_hot[g] = !is_ireg && (idx == IDX_W'(g));
    end

    always_comb begin
        field  = '0;
        nw_sel = 1'b0;
        for (int i = 0; i < N_CS; i++) begin
            if (idx == IDX_W'(i)) begin
                field  = wexp[FIELD_W*i +: FIELD_W];
                nw_sel = nowait[i];
            end
        end
    end

    // load_cnt = strobe length in clocks minus one
    always_comb begin
        if (is_ireg) begin
            load_cnt = ireg_slow ? CNT_W'(2) : CNT_W'(1);
            use_rdy  = 1'b0;
        end else if (nw_sel) begin
            load_cnt = '0;
            use_rdy  = 1'b0;
        end else begin
            load_cnt = wait_count(field);
            use_rdy  = 1'b1;
        end
    end

endmodule

// File: rtl/cswg_timer.sv
module cswg_timer #(
    parameter int N_CS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       wr,
    input  logic                       rdy,
    input  logic [N_CS-1:0]            cs_hot,
    input  logic                       is_ireg,
    input  logic [cswg_pkg::CNT_W-1:0] load_cnt,
    input  logic                       use_rdy,
    output logic                       strb,
    output logic [N_CS-1:0]            cs_sel,
    output logic                       ireg_sel,
    output logic                       wr_o
);
    import cswg_pkg::*;

    typedef struct packed {
        tstate_e          st;
        logic [CNT_W-1:0] cnt;
        logic [N_CS-1:0]  cs;
        logic             ireg;
        logic             wr;
        logic             use_rdy;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        case (tmr_q.st)
            ST_IDLE: begin
                if (req) begin
                    tmr_d.st      = ST_RUN;
                    tmr_d.cnt     = load_cnt;
                    tmr_d.cs      = cs_hot;
                    tmr_d.ireg    = is_ireg;
                    tmr_d.wr      = wr;
                    tmr_d.use_rdy = use_rdy;
                end
            end
            default: begin
                if (tmr_q.cnt != '0) begin
                    tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
                end else if (tmr_q.use_rdy && !rdy) begin
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.st      = ST_IDLE;
                    tmr_d.cs      = '0;
                    tmr_d.ireg    = 1'b0;
                    tmr_d.wr      = 1'b0;
                    tmr_d.use_rdy = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{st: ST_IDLE, default: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign strb     = (tmr_q.st == ST_RUN);
    assign cs_sel   = tmr_q.cs;
    assign ireg_sel = tmr_q.ireg;
    assign wr_o     = tmr_q.wr;

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen #(
    parameter int                N_CS       = 4,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] IREG_LIMIT = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rdy,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [2*N_CS-1:0] cfg_wdata,
    output logic              strb,
    output logic [N_CS-1:0]   cs_sel,
    output logic              ireg_sel,
    output logic              wr_o,
    output logic              cfg_err
);
    import cswg_pkg::*;

    logic [N_CS-1:0]   nowait;
    logic [2*N_CS-1:0] wexp;
    logic              ireg_slow;
    logic [N_CS-1:0]   cs_hot;
    logic              is_ireg;
    logic [CNT_W-1:0]  load_cnt;
    logic              use_rdy;

    cswg_cfg #(.N_CS(N_CS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .nowait    (nowait),
        .wexp      (wexp),
        .ireg_slow (ireg_slow),
        .cfg_err   (cfg_err)
    );

    cswg_decode #(.N_CS(N_CS), .ADDR_W(ADDR_W), .IREG_LIMIT(IREG_LIMIT)) u_dec (
        .addr      (addr),
        .nowait    (nowait),
        .wexp      (wexp),
        .ireg_slow (ireg_slow),
        .cs_hot    (cs_hot),
        .is_ireg   (is_ireg),
        .load_cnt  (load_cnt),
        .use_rdy   (use_rdy)
    );

    cswg_timer #(.N_CS(N_CS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .wr       (wr),
        .rdy      (rdy),
        .cs_hot   (cs_hot),
        .is_ireg  (is_ireg),
        .load_cnt (load_cnt),
        .use_rdy  (use_rdy),
        .strb     (strb),
        .cs_sel   (cs_sel),
        .ireg_sel (ireg_sel),
        .wr_o     (wr_o)
    );

endmodule

// File: rtl/cswg_checker.sv
module cswg_checker #(
    parameter int N_CS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            strb,
    input logic [N_CS-1:0] cs_sel,
    input logic            ireg_sel,
    input logic            wr_o,
    input logic            cfg_err
);
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!strb) begin
            run_q <= '0;
        end else if (run_q != 3'd7) begin
            run_q <= run_q + 3'd1;
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> ($countones({cs_sel, ireg_sel}) == 1)); // R2

    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |-> ((cs_sel == '0) && !ireg_sel && !wr_o)); // R2

    AST_NO_START_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && !req) |=> !strb); // R7

    AST_HELD_DURING_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && $past(strb)) |-> ($stable(cs_sel) && $stable(ireg_sel) && $stable(wr_o))); // R7

    AST_IREG_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && ireg_sel) |-> (run_q < 3'd3)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R10

endmodule

bind cs_wait_gen cswg_checker #(.N_CS(N_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .strb     (strb),
    .cs_sel   (cs_sel),
    .ireg_sel (ireg_sel),
    .wr_o     (wr_o),
    .cfg_err  (cfg_err)
);

// File: tb/sim_cs_wait_gen.sv
module sim_cs_wait_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        rdy = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        strb;
    logic [3:0]  cs_sel;
    logic        ireg_sel;
    logic        wr_o;
    logic        cfg_err;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    cs_wait_gen u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr(wr), .rdy(rdy),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .strb(strb), .cs_sel(cs_sel), .ireg_sel(ireg_sel), .wr_o(wr_o),
        .cfg_err(cfg_err)
    );

    // bench-side model of the control registers, written from the requirements
    logic [3:0] m_nw;
    logic [7:0] m_ex;
    logic       m_slow;
    logic       m_err;

    typedef struct {
        int         len;
        logic [3:0] cs;
        logic       ireg;
        logic       wr;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // monitor
    int         run = 0;
    logic [3:0] cur_cs;
    logic       cur_ir;
    logic       cur_wr;
    bit         moved = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (strb) begin
                if (run == 0) begin
                    cur_cs = cs_sel; cur_ir = ireg_sel; cur_wr = wr_o;
                end else if (cs_sel != cur_cs || ireg_sel != cur_ir || wr_o != cur_wr) begin
                    moved = 1;
                end
                run++;
            end else if (run > 0) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected cycle len=%0d expected no cycle", run);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (run != e.len || cur_cs != e.cs || cur_ir != e.ireg || cur_wr != e.wr || moved) begin
                        errors++;
                        $display("FAIL %s len=%0d cs=%b ir=%b wr=%b moved=%0d expected len=%0d cs=%b ir=%b wr=%b moved=0",
                                 e.tag, run, cur_cs, cur_ir, cur_wr, moved, e.len, e.cs, e.ireg, e.wr);
                    end
                end
                run = 0;
                moved = 0;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = 1'b0; cfg_we = 1'b0; rdy = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_nw = '0; m_ex = '0; m_slow = 1'b0; m_err = 1'b0;
        run = 0; moved = 0;
    endtask

    task automatic check_err(input string tag);
        checks++;
        if (cfg_err !== m_err) begin
            errors++;
            $display("FAIL %s cfg_err=%b expected %b", tag, cfg_err, m_err);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] data, input string tag);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (!sel) begin
            for (int i = 0; i < 4; i++) begin
                if (data[i] && !m_nw[i] && m_ex[2*i +: 2] != 2'b00) m_err = 1'b1;
                else m_nw[i] = data[i];
            end
            m_slow = data[4];
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (data[2*i +: 2] != m_ex[2*i +: 2]) begin
                    if (data[2*i +: 2] == 2'b11 || m_nw[i]) m_err = 1'b1;
                    else m_ex[2*i +: 2] = data[2*i +: 2];
                end
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check_err(tag);
    endtask

    task automatic access(input logic [15:0] a, input logic w, input int hold,
                          input bit poke, input string tag);
        exp_t e;
        int   base;
        bit   waitm;
        int   r;
        int   n;
        r = int'(a[15:14]);
        waitm = 0;
        if (a < 16'h0400) begin
            base = m_slow ? 3 : 2;
            e.cs = 4'b0000; e.ireg = 1'b1;
        end else begin
            e.cs = 4'b0001 << r; e.ireg = 1'b0;
            if (m_nw[r]) base = 1;
            else begin
                base = 2 + int'(m_ex[2*r +: 2]);
                waitm = 1;
            end
        end
        e.len = (waitm && hold > base) ? hold : base;
        e.wr = w;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req = 1'b1; addr = a; wr = w; rdy = (hold == 0);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req = 1'b0;
                if (poke) begin addr = 16'h0010; wr = ~w; end
            end
            if (poke && n == 2) begin req = 1'b1; addr = 16'h1000; end
            if (poke && n == 3) req = 1'b0;
            if (n >= hold) rdy = 1'b1;
            if (n >= hold && !strb) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        checks++;
        if (strb || cs_sel != 0 || ireg_sel || wr_o || cfg_err) begin
            errors++;
            $display("FAIL R1 strb=%b cs=%b ir=%b wr=%b err=%b expected all zero",
                     strb, cs_sel, ireg_sel, wr_o, cfg_err);
        end
        // R1 / R2 / R4: default timing, every region and direction
        access(16'h1000, 1'b0, 0, 0, "R1 region0 default");
        access(16'h4000, 1'b1, 0, 0, "R2 region1 default");
        access(16'h8123, 1'b0, 0, 0, "R2 region2 default");
        access(16'hC000, 1'b1, 0, 0, "R2 region3 default");
        access(16'h03FF, 1'b0, 0, 0, "R6 internal 2 clocks");
        // R4 packing and encodings
        cfg_write(1'b1, 8'b00_10_01_00, "R4 legal expansion write");
        access(16'h4000, 1'b0, 0, 0, "R4 region1 two waits");
        access(16'h8000, 1'b1, 0, 0, "R4 region2 three waits");
        access(16'hC000, 1'b0, 0, 0, "R4 region3 one wait");
        // R5 ready extension
        access(16'h8000, 1'b0, 7, 0, "R5 region2 stretched");
        access(16'h1000, 1'b1, 5, 0, "R5 region0 stretched");
        access(16'h8000, 1'b0, 3, 0, "R5 ready low before last wait only");
        // R6 internal slow, ignores ready
        cfg_write(1'b0, 8'b0001_0000, "R6 slow internal select");
        access(16'h0010, 1'b1, 0, 0, "R6 internal 3 clocks");
        access(16'h0010, 1'b0, 6, 0, "R6 internal ignores ready");
        // R7 request while busy and input changes ignored
        access(16'h8000, 1'b1, 6, 1, "R7 busy request ignored");
        // R10 illegal switch to no-wait
        cfg_write(1'b0, 8'b0000_0010, "R10 no-wait with field set");
        access(16'h4000, 1'b0, 0, 0, "R10 region1 kept waiting");
        cfg_write(1'b1, 8'b00_10_01_00, "R10 error sticky");
        // R8 reserved encoding
        do_reset();
        cfg_write(1'b1, 8'b00_00_00_11, "R8 reserved field write");
        access(16'h1000, 1'b0, 0, 0, "R8 region0 unchanged");
        // R3 / R9 no-wait region
        do_reset();
        cfg_write(1'b0, 8'b0000_1000, "R3 legal switch to no-wait");
        access(16'hC000, 1'b1, 0, 0, "R3 region3 single clock");
        access(16'hC000, 1'b0, 4, 0, "R3 region3 ignores ready");
        cfg_write(1'b1, 8'h00, "R9 same value no error");
        cfg_write(1'b1, 8'b01_00_00_00, "R9 field write while no-wait");
        access(16'hC000, 1'b0, 0, 0, "R9 region3 still single clock");
        access(16'h1000, 1'b1, 0, 0, "R9 region0 unaffected");
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R7 pending=%0d expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule